// File: doc/BRIEF.md
# Fieldbus input image update unit

This block maintains the input image that a fieldbus controller shares with a host CPU. Network variables arrive as update requests of two kinds. Data variables carry discrete and analog input values and land in the data region. Validator variables carry per-point and per-channel fault and alarm status and land in the validator region. Each request states whether the variable was consumed as a fresh, timely copy. When it was not, the block applies a fallback rule instead of the payload. For data, the fallback is set per variable. For validators, it depends on whether the variable is discrete or analog.

An accepted request is written into its slot one byte per clock, over a fixed number of cycles. While that write runs, a status output is high and new requests are dropped. The CPU side reads the image through a synchronous read port with one cycle of latency.

The image is a flat byte space. Data variable `i` occupies bytes `i*SLOT_BYTES` onward. Validator variable `j` occupies bytes `N_DATA*SLOT_BYTES + j*SLOT_BYTES` onward. Each analog validator byte uses bit 0 for point fault, bit 1 for high alarm and bit 2 for low alarm; bits 7:3 are reserved. Each bit of a discrete validator byte is the point-fault flag of one input point.

Top module: `fbi_input_image`

## Requirements
- R1: After reset, every data byte reads 0x00, every byte of a discrete validator slot reads 0xFF, and every byte of an analog validator slot reads 0x01.
- R2: A request with `upd_valid` high while `upd_busy` is low is accepted. `upd_busy` is high from the next cycle for exactly SLOT_BYTES cycles. Payload byte b (bits 8b+7:8b) is written to slot offset b, one byte per cycle in ascending order.
- R3: A request presented while `upd_busy` is high is ignored and changes no byte of the image.
- R4: A consumed data variable (`upd_kind`=0, `upd_consumed`=1) has its slot overwritten by the payload.
- R5: A data variable not consumed whose `cfg_data_hold` bit is 0 has every byte of its slot cleared to 0x00.
- R6: A data variable not consumed whose `cfg_data_hold` bit is 1 leaves its slot unchanged.
- R7: A consumed validator variable (`upd_kind`=1) is stored exactly as received, reserved bits included.
- R8: A discrete validator (`cfg_val_analog` bit 0) that was not consumed has every byte of its slot set to 0xFF.
- R9: An analog validator (`cfg_val_analog` bit 1) that was not consumed has bit 0 of every byte set. Bits 7:1, which include both alarm bits, keep their previous values.
- R10: `cpu_rd_data` shows the byte at `cpu_addr` one cycle after `cpu_rd_en` is sampled high, and holds its value while `cpu_rd_en` is low. A read in the same cycle as a write to that byte returns the value from before the write.
- R11: `upd_busy` is low after reset and high exactly while an accepted update is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data_hold | input | N_DATA | Per data variable: 1 = keep last value, 0 = clear, when not consumed |
| cfg_val_analog | input | N_VAL | Per validator variable: 1 = analog byte-per-channel, 0 = discrete bit-per-point |
| upd_valid | input | 1 | Update request strobe |
| upd_kind | input | 1 | 0 = data variable, 1 = validator variable |
| upd_index | input | IDX_W | Variable index within its kind |
| upd_consumed | input | 1 | 1 = fresh, timely copy received |
| upd_payload | input | SLOT_BYTES*8 | Variable payload, byte b in bits 8b+7:8b |
| upd_busy | output | 1 | Update in progress |
| cpu_rd_en | input | 1 | CPU read enable |
| cpu_addr | input | ADDR_W | CPU byte address in the image |
| cpu_rd_data | output | 8 | CPU read data, one cycle latency |

## Verification
On every cycle, the assertions check the per-byte fallback rules at the write port. They check that each byte written by a consumed update equals the payload byte, that each unconsumed data byte with the clear policy is zero, that unconsumed discrete validators write 0xFF, and that unconsumed analog validators write a byte with the fault bit set. They also check the busy window length, the start of an update on acceptance, that the latched request is stable during an update, and that read data holds while no read is enabled. Only the bench's scenarios can show whole-image effects. These are that held data and analog alarm bits survive across several updates, that a request dropped while busy leaves its target untouched, and that a read colliding with a write returns the old byte.

// File: rtl/fbi_pkg.sv
package fbi_pkg;

    localparam logic [7:0] FAULT_MASK  = 8'h01;
    localparam logic [7:0] ALL_FAULTED = 8'hFF;

    typedef enum logic {
        VK_DATA  = 1'b0,
        VK_VALID = 1'b1
    } var_kind_e;

    typedef struct packed {
        var_kind_e kind;
        logic      consumed;
        logic      hold;
        logic      analog;
    } upd_ctl_t;

    // New image byte from the old byte, the received byte and the update's controls.
    function automatic logic [7:0] merge_byte(upd_ctl_t c, logic [7:0] old_b, logic [7:0] new_b);
        logic [7:0] r;
        if (c.consumed) begin
            r = new_b;
        end else if (c.kind == VK_DATA) begin
            r = c.hold ? old_b : 8'h00;
        end else if (c.analog) begin
            r = old_b | FAULT_MASK;
        end else begin
            r = ALL_FAULTED;
        end
        return r;
    endfunction

endpackage

// File: rtl/fbi_seq.sv
module fbi_seq
    import fbi_pkg::*;
#(
    parameter int N_DATA     = 4,
    parameter int N_VAL      = 4,
    parameter int SLOT_BYTES = 16,
    parameter int IDX_W      = 2,
    parameter int ADDR_W     = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_DATA-1:0]       cfg_data_hold,
    input  logic [N_VAL-1:0]        cfg_val_analog,
    input  logic                    upd_valid,
    input  logic                    upd_kind,
    input  logic [IDX_W-1:0]        upd_index,
    input  logic                    upd_consumed,
    input  logic [SLOT_BYTES*8-1:0] upd_payload,
    output logic                    busy,
    output logic                    wr_en,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [7:0]              wr_fresh,
    output upd_ctl_t                wr_ctl,
    output logic [IDX_W-1:0]        idx_q
);

    localparam int CNT_W      = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1;
    localparam int DATA_BYTES = N_DATA * SLOT_BYTES;

    logic                    busy_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [ADDR_W-1:0]       base_q;
    logic [SLOT_BYTES*8-1:0] payload_q;
    upd_ctl_t                ctl_q;
    logic                    accept;
    logic [ADDR_W-1:0]       slot_base;
    upd_ctl_t                ctl_d;

    assign accept = upd_valid && !busy_q;

    always_comb begin
        ctl_d.kind     = var_kind_e'(upd_kind);
        ctl_d.consumed = upd_consumed;
        ctl_d.hold     = cfg_data_hold[upd_index];
        ctl_d.analog   = cfg_val_analog[upd_index];
        slot_base      = ADDR_W'(upd_index) * ADDR_W'(SLOT_BYTES);
        if (ctl_d.kind == VK_VALID) begin
            slot_base = slot_base + ADDR_W'(DATA_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            base_q    <= '0;
            payload_q <= '0;
            ctl_q     <= '0;
            idx_q     <= '0;
        end else if (accept) begin
            busy_q    <= 1'b1;
            cnt_q     <= '0;
            base_q    <= slot_base;
            payload_q <= upd_payload;
            ctl_q     <= ctl_d;
            idx_q     <= upd_index;
        end else if (busy_q) begin
            cnt_q     <= cnt_q + 1'b1;
            payload_q <= payload_q >> 8;
            if (cnt_q == CNT_W'(SLOT_BYTES - 1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy     = busy_q;
    assign wr_en    = busy_q;
    assign wr_addr  = base_q + ADDR_W'(cnt_q);
    assign wr_fresh = payload_q[7:0];
    assign wr_ctl   = ctl_q;

endmodule

// File: rtl/fbi_image.sv
module fbi_image
    import fbi_pkg::*;
#(
    parameter int N_DATA     = 4,
    parameter int N_VAL      = 4,
    parameter int SLOT_BYTES = 16,
    parameter int ADDR_W     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_VAL-1:0]  cfg_val_analog,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_fresh,
    input  upd_ctl_t          wr_ctl,
    output logic [7:0]        wr_data,
    input  logic              cpu_rd_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [7:0]        cpu_rd_data
);

    localparam int DATA_BYTES  = N_DATA * SLOT_BYTES;
    localparam int TOTAL_BYTES = (N_DATA + N_VAL) * SLOT_BYTES;

    logic [7:0] mem     [TOTAL_BYTES];
    logic [7:0] rst_val [TOTAL_BYTES];

    for (genvar a = 0; a < TOTAL_BYTES; a++) begin : g_rst
        if (a < DATA_BYTES) begin : g_data
            assign rst_val[a] = 8'h00;
        end else begin : g_valid
            assign rst_val[a] = cfg_val_analog[(a - DATA_BYTES) / SLOT_BYTES] ? FAULT_MASK : ALL_FAULTED;
        end
    end

    assign wr_data = merge_byte(wr_ctl, mem[wr_addr], wr_fresh);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < TOTAL_BYTES; a++) begin
                mem[a] <= rst_val[a];
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rd_data <= 8'h00;
        end else if (cpu_rd_en) begin
            cpu_rd_data <= mem[cpu_addr];
        end
    end

endmodule

// File: rtl/fbi_input_image.sv
module fbi_input_image
    import fbi_pkg::*;
#(
    parameter int N_DATA     = 4,
    parameter int N_VAL      = 4,
    parameter int SLOT_BYTES = 16,
    localparam int N_MAX       = (N_DATA > N_VAL) ? N_DATA : N_VAL,
    localparam int IDX_W       = (N_MAX > 1) ? $clog2(N_MAX) : 1,
    localparam int TOTAL_BYTES = (N_DATA + N_VAL) * SLOT_BYTES,
    localparam int ADDR_W      = (TOTAL_BYTES > 1) ? $clog2(TOTAL_BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_DATA-1:0]       cfg_data_hold,
    input  logic [N_VAL-1:0]        cfg_val_analog,
    input  logic                    upd_valid,
    input  logic                    upd_kind,
    input  logic [IDX_W-1:0]        upd_index,
    input  logic                    upd_consumed,
    input  logic [SLOT_BYTES*8-1:0] upd_payload,
    output logic                    upd_busy,
    input  logic                    cpu_rd_en,
    input  logic [ADDR_W-1:0]       cpu_addr,
    output logic [7:0]              cpu_rd_data
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_fresh;
    logic [7:0]        wr_data;
    upd_ctl_t          wr_ctl;
    logic [IDX_W-1:0]  idx_q;

    fbi_seq #(
        .N_DATA(N_DATA), .N_VAL(N_VAL), .SLOT_BYTES(SLOT_BYTES),
        .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_seq (
        .clk(clk), .rst(rst),
        .cfg_data_hold(cfg_data_hold), .cfg_val_analog(cfg_val_analog),
        .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_index(upd_index),
        .upd_consumed(upd_consumed), .upd_payload(upd_payload),
        .busy(upd_busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_fresh(wr_fresh), .wr_ctl(wr_ctl), .idx_q(idx_q)
    );

    fbi_image #(
        .N_DATA(N_DATA), .N_VAL(N_VAL), .SLOT_BYTES(SLOT_BYTES), .ADDR_W(ADDR_W)
    ) u_image (
        .clk(clk), .rst(rst), .cfg_val_analog(cfg_val_analog),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_fresh(wr_fresh), .wr_ctl(wr_ctl),
        .wr_data(wr_data),
        .cpu_rd_en(cpu_rd_en), .cpu_addr(cpu_addr), .cpu_rd_data(cpu_rd_data)
    );

endmodule

// File: rtl/fbi_input_image_chk.sv
module fbi_input_image_chk
    import fbi_pkg::*;
#(
    parameter int SLOT_BYTES = 16,
    parameter int IDX_W      = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             upd_valid,
    input logic             upd_busy,
    input logic             wr_en,
    input upd_ctl_t         wr_ctl,
    input logic [7:0]       wr_fresh,
    input logic [7:0]       wr_data,
    input logic [IDX_W-1:0] idx_q,
    input logic             cpu_rd_en,
    input logic [7:0]       cpu_rd_data
);

    logic [15:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !upd_busy) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 16'd1;
        end
    end

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_busy) |=> upd_busy);

    // R2
    busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        upd_busy |-> (run_cnt < 16'(SLOT_BYTES)));

    // R11
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_busy) |-> ($past(run_cnt) == 16'(SLOT_BYTES - 1)));

    // R3
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_busy && $past(upd_busy)) |-> $stable(idx_q));

    // R4
    consumed_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctl.consumed) |-> (wr_data == wr_fresh));

    // R5
    data_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctl.kind == VK_DATA && !wr_ctl.consumed && !wr_ctl.hold) |-> (wr_data == 8'h00));

    // R8
    disc_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctl.kind == VK_VALID && !wr_ctl.consumed && !wr_ctl.analog) |-> (wr_data == 8'hFF));

    // R9
    ana_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctl.kind == VK_VALID && !wr_ctl.consumed && wr_ctl.analog) |-> wr_data[0]);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd_en |=> $stable(cpu_rd_data));

endmodule

bind fbi_input_image fbi_input_image_chk #(
    .SLOT_BYTES(SLOT_BYTES), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_busy(upd_busy),
    .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_fresh(wr_fresh), .wr_data(wr_data),
    .idx_q(idx_q), .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data)
);

// File: tb/fbi_input_image_bench.sv
module fbi_input_image_bench;

    localparam int ND    = 4;
    localparam int NV    = 4;
    localparam int SB    = 16;
    localparam int TOTAL = (ND + NV) * SB;
    localparam int VBASE = ND * SB;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [ND-1:0]   cfg_data_hold  = 4'b0010;
    logic [NV-1:0]   cfg_val_analog = 4'b0101;
    logic            upd_valid = 1'b0;
    logic            upd_kind = 1'b0;
    logic [1:0]      upd_index = '0;
    logic            upd_consumed = 1'b0;
    logic [SB*8-1:0] upd_payload = '0;
    logic            upd_busy;
    logic            cpu_rd_en = 1'b0;
    logic [6:0]      cpu_addr = '0;
    logic [7:0]      cpu_rd_data;

    int checks = 0;
    int errors = 0;

    fbi_input_image u_fbi_input_image (
        .clk(clk), .rst(rst), .cfg_data_hold(cfg_data_hold), .cfg_val_analog(cfg_val_analog),
        .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_index(upd_index),
        .upd_consumed(upd_consumed), .upd_payload(upd_payload), .upd_busy(upd_busy),
        .cpu_rd_en(cpu_rd_en), .cpu_addr(cpu_addr), .cpu_rd_data(cpu_rd_data)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: byte image plus a queue of pending byte writes.
    typedef struct { int a; logic [7:0] v; } wop_t;
    logic [7:0] mem_m [TOTAL];
    wop_t       pend [$];
    logic [7:0] exp_rd = 8'h00;

    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < TOTAL; a++)
                mem_m[a] = (a < VBASE) ? 8'h00 : (cfg_val_analog[(a - VBASE) / SB] ? 8'h01 : 8'hFF);
            pend.delete();
            exp_rd = 8'h00;
        end else begin
            if (cpu_rd_en) exp_rd = mem_m[cpu_addr];
            if (pend.size() > 0) begin
                wop_t w;
                w = pend.pop_front();
                mem_m[w.a] = w.v;
            end else if (upd_valid) begin
                int base;
                base = (upd_kind ? VBASE : 0) + int'(upd_index) * SB;
                for (int b = 0; b < SB; b++) begin
                    wop_t w;
                    logic [7:0] old, p;
                    old = mem_m[base + b];
                    p = upd_payload[8*b +: 8];
                    if (upd_consumed) w.v = p;
                    else if (!upd_kind) w.v = cfg_data_hold[upd_index] ? old : 8'h00;
                    else w.v = cfg_val_analog[upd_index] ? (old | 8'h01) : 8'hFF;
                    w.a = base + b;
                    pend.push_back(w);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(cpu_rd_data == exp_rd, "R10 model read data", cpu_rd_data, exp_rd);
            chk(upd_busy == (pend.size() != 0), "R11 model busy", 8'(upd_busy), 8'(pend.size() != 0));
        end
    end

    function automatic logic [SB*8-1:0] ramp(input logic [7:0] first);
        logic [SB*8-1:0] r;
        for (int b = 0; b < SB; b++) r[8*b +: 8] = first + 8'(b);
        return r;
    endfunction

    task automatic send(input logic kind, input logic [1:0] idx, input logic cons,
                        input logic [SB*8-1:0] pl, output int busy_cycles);
        @(negedge clk);
        upd_valid = 1'b1; upd_kind = kind; upd_index = idx;
        upd_consumed = cons; upd_payload = pl;
        @(negedge clk);
        upd_valid = 1'b0;
        busy_cycles = 0;
        while (upd_busy) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic rd_expect(input int addr, input logic [7:0] exp, input string req);
        @(negedge clk);
        cpu_rd_en = 1'b1; cpu_addr = 7'(addr);
        @(negedge clk);
        cpu_rd_en = 1'b0;
        chk(cpu_rd_data == exp, req, cpu_rd_data, exp);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [SB*8-1:0] pl;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset image
        rd_expect(5, 8'h00, "R1 data byte after reset");
        rd_expect(VBASE + 0, 8'h01, "R1 analog validator after reset");
        rd_expect(VBASE + SB + 3, 8'hFF, "R1 discrete validator after reset");
        chk(upd_busy == 1'b0, "R11 idle after reset", 8'(upd_busy), 8'h00);

        // Consumed data, timing of the write window
        send(1'b0, 2'd1, 1'b1, ramp(8'h10), n);
        chk(n == SB, "R2 busy window length", 8'(n), 8'(SB));
        rd_expect(SB + 3, 8'h13, "R4 data var1 byte3");
        rd_expect(SB + 15, 8'h1F, "R2 data var1 last byte");
        send(1'b0, 2'd0, 1'b1, ramp(8'hA0), n);
        rd_expect(2, 8'hA2, "R4 data var0 byte2");

        // Unconsumed data: clear vs hold
        send(1'b0, 2'd0, 1'b0, {SB{8'h55}}, n);
        rd_expect(2, 8'h00, "R5 data var0 cleared");
        send(1'b0, 2'd1, 1'b0, {SB{8'h55}}, n);
        rd_expect(SB + 3, 8'h13, "R6 data var1 held");

        // Analog validator consumed then lost
        pl = '0; pl[7:0] = 8'h06; pl[15:8] = 8'hF8;
        send(1'b1, 2'd0, 1'b1, pl, n);
        rd_expect(VBASE + 0, 8'h06, "R7 analog alarms stored");
        rd_expect(VBASE + 1, 8'hF8, "R7 reserved bits stored");
        send(1'b1, 2'd0, 1'b0, {SB{8'h00}}, n);
        rd_expect(VBASE + 0, 8'h07, "R9 alarms kept fault set");
        rd_expect(VBASE + 1, 8'hF9, "R9 reserved kept fault set");
        rd_expect(VBASE + 2, 8'h01, "R9 cleared byte gets fault");

        // Discrete validator consumed then lost
        send(1'b1, 2'd1, 1'b1, {SB{8'h00}}, n);
        rd_expect(VBASE + SB, 8'h00, "R7 discrete validator stored");
        send(1'b1, 2'd1, 1'b0, {SB{8'h00}}, n);
        rd_expect(VBASE + SB, 8'hFF, "R8 discrete fault first byte");
        rd_expect(VBASE + SB + 15, 8'hFF, "R8 discrete fault last byte");

        // Request during busy is dropped
        @(negedge clk);
        upd_valid = 1'b1; upd_kind = 1'b0; upd_index = 2'd2;
        upd_consumed = 1'b1; upd_payload = {SB{8'h33}};
        @(negedge clk);
        upd_index = 2'd3; upd_payload = {SB{8'h77}};
        @(negedge clk);
        upd_valid = 1'b0;
        while (upd_busy) @(negedge clk);
        rd_expect(3 * SB, 8'h00, "R3 var3 untouched");
        rd_expect(2 * SB + 7, 8'h33, "R4 var2 written");

        // Read colliding with the write of the same byte returns old value
        @(negedge clk);
        upd_valid = 1'b1; upd_kind = 1'b0; upd_index = 2'd1;
        upd_consumed = 1'b1; upd_payload = ramp(8'hC0);
        @(negedge clk);
        upd_valid = 1'b0; cpu_rd_en = 1'b1; cpu_addr = 7'(SB);
        @(negedge clk);
        cpu_rd_en = 1'b0;
        chk(cpu_rd_data == 8'h10, "R10 collision returns old", cpu_rd_data, 8'h10);
        while (upd_busy) @(negedge clk);
        rd_expect(SB, 8'hC0, "R10 new value after write");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule